// File: doc/BRIEF.md
# Pipeline Interlock Stall Unit

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline may advance. The five stages are fetch, decode, execute, memory and writeback. The pipeline has no bypass paths, so a source operand is valid only once its producer has left writeback. The unit takes the two source register fields of the decode instruction and a flag for each that says whether the instruction reads it. It compares both fields against the destination register and write enable of the instructions now in execute, memory and writeback.

On any match the unit holds the program counter and the fetch/decode pipeline register. It also turns the slot entering execute into a bubble whose register-write and memory-write controls are forced low. The three downstream stages are never held; they drain. Once the producer has retired, the comparison no longer matches and decode advances. The logic is purely combinational from the current stage registers. A dependent instruction at distance one, two or three loses three, two or one cycle, and CPI equals (instructions + stall cycles) / instructions.

Top module: `interlockUnit`

## Requirements
- R1: `idExBubble` is 1 when `decReadsRs` is 1, `decRs` is nonzero, and `decRs` equals the destination of some later stage whose `laterRegWrite` bit is 1. Bits [4:0] of `laterDest` belong to execute, [9:5] to memory and [14:10] to writeback; `laterRegWrite` bits 0, 1 and 2 belong to the same stages.
- R2: The same three-stage match on `decRt`, gated by `decReadsRt`, also sets `idExBubble` to 1.
- R3: A source field equal to register 0 never causes a stall, even when a later stage writes register 0.
- R4: A source field whose read flag is 0 never causes a stall, whatever the later stages hold.
- R5: A later stage whose `laterRegWrite` bit is 0 never causes a stall, even if its destination matches.
- R6: While stalling, `pcWrEn` and `ifIdWrEn` are both 0. Otherwise both are 1.
- R7: While stalling, `idExRegWrite` and `idExMemWrite` are 0. Otherwise they equal `decRegWrite` and `decMemWrite`.
- R8: The stall depends only on the present inputs. It drops in the same cycle that no later stage holds a matching write, so a consumer at distance four or more never stalls.
- R9: In a pipeline built around the unit, a consumer at distance 1, 2 or 3 from its producer stalls exactly 3, 2 or 1 cycles. The span from the first retirement to the last equals instructions plus stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decRs | input | 5 | First source register field of the decode instruction |
| decRt | input | 5 | Second source register field of the decode instruction |
| decReadsRs | input | 1 | Decode instruction reads its first source |
| decReadsRt | input | 1 | Decode instruction reads its second source |
| laterDest | input | 15 | Destinations of execute [4:0], memory [9:5], writeback [14:10] |
| laterRegWrite | input | 3 | Register-write enables of execute (0), memory (1), writeback (2) |
| decRegWrite | input | 1 | Register-write control decoded for the decode instruction |
| decMemWrite | input | 1 | Memory-write control decoded for the decode instruction |
| pcWrEn | output | 1 | Program counter update enable |
| ifIdWrEn | output | 1 | Fetch/decode pipeline register load enable |
| idExBubble | output | 1 | Slot entering execute is a bubble |
| idExRegWrite | output | 1 | Register-write control loaded into the execute slot |
| idExMemWrite | output | 1 | Memory-write control loaded into the execute slot |

## Verification
The table walk hits each of the six stage/operand pairs alone. A comparator wired to the wrong stage or the wrong field would miss one of them and let a stale operand through. Other vectors match a destination while the write enable, the read flag or a nonzero field is missing; a design that skipped any of those gates would stall with no dependence present. A small pipeline model then runs a program with dependences at distances one to four. Counting stall cycles per consumer exposes an off-by-one in the stage window, either a missed writeback check or a stall that lingers after the producer retires. A bubble that kept its write controls would show as a wrong `idExRegWrite` or `idExMemWrite` during a stall.

// File: rtl/interlockPkg.sv
package interlockPkg;

  // Strobes sent from the stall control to the datapath gating.
  typedef struct packed {
    logic holdFront;     // freeze PC and fetch/decode register
    logic insertBubble;  // turn the execute-bound slot into a no-op
  } stallStrobe_t;

  // Operand slots checked against later stages.
  localparam int OPERAND_N = 2;
  localparam int OP_FIRST  = 0;
  localparam int OP_SECOND = 1;

endpackage

// File: rtl/hazardDatapath.sv
module hazardDatapath
  import interlockPkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int LATER_N = 3,
  localparam int HIT_N  = OPERAND_N * LATER_N
) (
  input  logic [REG_AW-1:0]         decRs,
  input  logic [REG_AW-1:0]         decRt,
  input  logic                      decReadsRs,
  input  logic                      decReadsRt,
  input  logic [LATER_N*REG_AW-1:0] laterDest,
  input  logic [LATER_N-1:0]        laterRegWrite,
  input  logic                      decRegWrite,
  input  logic                      decMemWrite,
  input  stallStrobe_t              strobes,
  output logic [HIT_N-1:0]          hitVec,
  output logic                      pcWrEn,
  output logic                      ifIdWrEn,
  output logic                      idExBubble,
  output logic                      idExRegWrite,
  output logic                      idExMemWrite
);

  logic [REG_AW-1:0] opField [OPERAND_N];
  logic [OPERAND_N-1:0] opLive;

  // A field only counts when it is read and is not the hardwired zero register.
  always_comb begin
    opField[OP_FIRST]  = decRs;
    opField[OP_SECOND] = decRt;
    opLive[OP_FIRST]   = decReadsRs && (decRs != '0);
    opLive[OP_SECOND]  = decReadsRt && (decRt != '0);
  end

  // One comparator for each operand and later stage.
  for (genvar op = 0; op < OPERAND_N; op++) begin : g_op
    for (genvar st = 0; st < LATER_N; st++) begin : g_st
      logic [REG_AW-1:0] stDest;
      assign stDest = laterDest[st*REG_AW +: REG_AW];
      assign hitVec[op*LATER_N + st] =
        opLive[op] && laterRegWrite[st] && (stDest == opField[op]);
    end
  end

  // Front-end enables and the execute-bound control gating.
  always_comb begin
    pcWrEn       = !strobes.holdFront;
    ifIdWrEn     = !strobes.holdFront;
    idExBubble   = strobes.insertBubble;
    idExRegWrite = decRegWrite && !strobes.insertBubble;
    idExMemWrite = decMemWrite && !strobes.insertBubble;
  end

endmodule

// File: rtl/hazardControl.sv
module hazardControl
  import interlockPkg::*;
#(
  parameter int LATER_N = 3,
  localparam int HIT_N  = OPERAND_N * LATER_N
) (
  input  logic [HIT_N-1:0] hitVec,
  output stallStrobe_t     strobes
);

  logic [OPERAND_N-1:0] opBlocked;

  // Reduce the hits of each operand over all later stages.
  for (genvar op = 0; op < OPERAND_N; op++) begin : g_red
    assign opBlocked[op] = |hitVec[op*LATER_N +: LATER_N];
  end

  always_comb begin
    strobes.holdFront    = |opBlocked;
    strobes.insertBubble = |opBlocked;
  end

endmodule

// File: rtl/interlockUnit.sv
module interlockUnit
  import interlockPkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int LATER_N = 3,
  localparam int HIT_N  = OPERAND_N * LATER_N
) (
  input  logic [REG_AW-1:0]         decRs,
  input  logic [REG_AW-1:0]         decRt,
  input  logic                      decReadsRs,
  input  logic                      decReadsRt,
  input  logic [LATER_N*REG_AW-1:0] laterDest,
  input  logic [LATER_N-1:0]        laterRegWrite,
  input  logic                      decRegWrite,
  input  logic                      decMemWrite,
  output logic                      pcWrEn,
  output logic                      ifIdWrEn,
  output logic                      idExBubble,
  output logic                      idExRegWrite,
  output logic                      idExMemWrite
);

  logic [HIT_N-1:0] hitVec;
  stallStrobe_t     strobes;

  hazardDatapath #(.REG_AW(REG_AW), .LATER_N(LATER_N)) u_dp (
    .decRs(decRs), .decRt(decRt),
    .decReadsRs(decReadsRs), .decReadsRt(decReadsRt),
    .laterDest(laterDest), .laterRegWrite(laterRegWrite),
    .decRegWrite(decRegWrite), .decMemWrite(decMemWrite),
    .strobes(strobes), .hitVec(hitVec),
    .pcWrEn(pcWrEn), .ifIdWrEn(ifIdWrEn), .idExBubble(idExBubble),
    .idExRegWrite(idExRegWrite), .idExMemWrite(idExMemWrite)
  );

  hazardControl #(.LATER_N(LATER_N)) u_ctl (
    .hitVec(hitVec),
    .strobes(strobes)
  );

endmodule

// File: rtl/interlockChecker.sv
module interlockChecker #(
  parameter int REG_AW  = 5,
  parameter int LATER_N = 3
) (
  input logic [REG_AW-1:0]         decRs,
  input logic [REG_AW-1:0]         decRt,
  input logic                      decReadsRs,
  input logic                      decReadsRt,
  input logic [LATER_N*REG_AW-1:0] laterDest,
  input logic [LATER_N-1:0]        laterRegWrite,
  input logic                      decRegWrite,
  input logic                      decMemWrite,
  input logic                      pcWrEn,
  input logic                      ifIdWrEn,
  input logic                      idExBubble,
  input logic                      idExRegWrite,
  input logic                      idExMemWrite
);

  always_comb begin
    // R6
    front_hold_chk: assert (pcWrEn == ifIdWrEn && idExBubble == !pcWrEn)
      else $error("front enables disagree with bubble");
    // R3
    zero_reg_chk: assert (!(decRs == '0 && decRt == '0) || !idExBubble)
      else $error("stall raised for register zero sources");
    // R4
    no_read_chk: assert (decReadsRs || decReadsRt || !idExBubble)
      else $error("stall raised with no operand read");
    // R5
    no_write_chk: assert (laterRegWrite != '0 || !idExBubble)
      else $error("stall raised with no later write");
    // R7
    bubble_ctrl_chk: assert (!idExBubble || (!idExRegWrite && !idExMemWrite))
      else $error("bubble carries write controls");
    // R7
    pass_ctrl_chk: assert (idExBubble ||
                           (idExRegWrite == decRegWrite && idExMemWrite == decMemWrite))
      else $error("decode controls not passed through");
    // R1
    ex_rs_hit_chk: assert (!(decReadsRs && decRs != '0 && laterRegWrite[0] &&
                             laterDest[REG_AW-1:0] == decRs) || idExBubble)
      else $error("first source hit in execute did not stall");
  end

endmodule

bind interlockUnit interlockChecker #(.REG_AW(REG_AW), .LATER_N(LATER_N)) u_chk (
  .decRs(decRs), .decRt(decRt),
  .decReadsRs(decReadsRs), .decReadsRt(decReadsRt),
  .laterDest(laterDest), .laterRegWrite(laterRegWrite),
  .decRegWrite(decRegWrite), .decMemWrite(decMemWrite),
  .pcWrEn(pcWrEn), .ifIdWrEn(ifIdWrEn), .idExBubble(idExBubble),
  .idExRegWrite(idExRegWrite), .idExMemWrite(idExMemWrite)
);

// File: tb/sim_interlockUnit.sv
module sim_interlockUnit;

  localparam int AW = 5;
  localparam int LN = 3;
  localparam int VEC_N = 15;
  localparam int PROG_N = 14;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz
  logic rstN = 1'b0;

  logic [AW-1:0]    decRs, decRt;
  logic             decReadsRs, decReadsRt;
  logic [LN*AW-1:0] laterDest;
  logic [LN-1:0]    laterRegWrite;
  logic             decRegWrite, decMemWrite;
  logic             pcWrEn, ifIdWrEn, idExBubble, idExRegWrite, idExMemWrite;

  interlockUnit #(.REG_AW(AW), .LATER_N(LN)) u0 (
    .decRs(decRs), .decRt(decRt),
    .decReadsRs(decReadsRs), .decReadsRt(decReadsRt),
    .laterDest(laterDest), .laterRegWrite(laterRegWrite),
    .decRegWrite(decRegWrite), .decMemWrite(decMemWrite),
    .pcWrEn(pcWrEn), .ifIdWrEn(ifIdWrEn), .idExBubble(idExBubble),
    .idExRegWrite(idExRegWrite), .idExMemWrite(idExMemWrite)
  );

  // rs, rt, rdRs, rdRt, dEx, dMem, dWb, we[2:0], decRw, decMw, expectStall
  localparam int VECS [VEC_N][11] = '{
    '{3, 4, 1, 1, 1, 2, 6, 7, 1, 0, 0},  // R1 no match
    '{3, 4, 1, 1, 3, 2, 6, 1, 1, 0, 1},  // R1 rs vs execute
    '{3, 4, 1, 1, 1, 3, 6, 2, 1, 0, 1},  // R1 rs vs memory
    '{3, 4, 1, 1, 1, 2, 3, 4, 0, 1, 1},  // R1 rs vs writeback
    '{3, 4, 1, 1, 4, 2, 6, 1, 1, 0, 1},  // R2 rt vs execute
    '{3, 4, 1, 1, 1, 4, 6, 2, 1, 0, 1},  // R2 rt vs memory
    '{3, 4, 1, 1, 1, 2, 4, 4, 1, 0, 1},  // R2 rt vs writeback
    '{3, 4, 1, 1, 3, 3, 3, 0, 1, 0, 0},  // R5 no write enables
    '{3, 4, 1, 1, 3, 2, 6, 6, 1, 0, 0},  // R5 match only where disabled
    '{3, 4, 0, 1, 3, 3, 3, 7, 1, 0, 0},  // R4 rs not read
    '{3, 4, 1, 0, 4, 4, 4, 7, 1, 0, 0},  // R4 rt not read
    '{0, 0, 1, 1, 0, 0, 0, 7, 1, 1, 0},  // R3 zero register
    '{0, 4, 1, 1, 0, 0, 4, 4, 1, 0, 1},  // R3 zero rs, rt hits writeback
    '{3, 3, 1, 1, 3, 3, 3, 7, 1, 1, 1},  // R1 all stages match
    '{3, 4, 1, 1, 1, 2, 6, 7, 0, 1, 0}   // R7 pass store controls
  };

  function automatic string tagOf(int i);
    case (i)
      4, 5, 6: return "R2";
      7, 8:    return "R5";
      9, 10:   return "R4";
      11, 12:  return "R3";
      14:      return "R7";
      default: return "R1";
    endcase
  endfunction

  int checks = 0;
  int fails = 0;
  bit doneFlag = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  // Program for the pipeline model.
  typedef struct {
    int dest; bit we; int rs; int rt; bit rdRs; bit rdRt;
  } inst_t;

  function automatic inst_t progAt(int i);
    inst_t x = '{0, 1'b0, 1, 3, 1'b1, 1'b1};
    case (i)
      0:  x = '{5, 1'b1, 0, 0, 1'b0, 1'b0};
      1:  x = '{0, 1'b0, 5, 0, 1'b1, 1'b1};   // distance 1
      2:  x = '{7, 1'b1, 0, 0, 1'b0, 1'b0};
      4:  x = '{0, 1'b0, 3, 7, 1'b1, 1'b1};   // distance 2
      5:  x = '{9, 1'b1, 0, 0, 1'b0, 1'b0};
      8:  x = '{0, 1'b0, 9, 4, 1'b1, 1'b1};   // distance 3
      9:  x = '{2, 1'b1, 0, 0, 1'b0, 1'b0};
      13: x = '{0, 1'b0, 4, 2, 1'b1, 1'b1};   // distance 4
      default: ;
    endcase
    return x;
  endfunction

  task automatic driveVec(int i);
    decRs         = AW'(VECS[i][0]);
    decRt         = AW'(VECS[i][1]);
    decReadsRs    = VECS[i][2] != 0;
    decReadsRt    = VECS[i][3] != 0;
    laterDest     = {AW'(VECS[i][6]), AW'(VECS[i][5]), AW'(VECS[i][4])};
    laterRegWrite = LN'(VECS[i][7]);
    decRegWrite   = VECS[i][8] != 0;
    decMemWrite   = VECS[i][9] != 0;
  endtask

  task automatic checkOuts(string req, int stallExp, int rwExp, int mwExp);
    chk("R6", {req, " pcWrEn"}, int'(pcWrEn), 1 - stallExp);
    chk("R6", {req, " ifIdWrEn"}, int'(ifIdWrEn), 1 - stallExp);
    chk(req, "idExBubble", int'(idExBubble), stallExp);
    chk("R7", {req, " idExRegWrite"}, int'(idExRegWrite), stallExp != 0 ? 0 : rwExp);
    chk("R7", {req, " idExMemWrite"}, int'(idExMemWrite), stallExp != 0 ? 0 : mwExp);
  endtask

  int idIdx, exIdx, memIdx, wbIdx, pcIdx;
  int cyc, stalls, retired, firstRet, lastRet;
  int perStall [PROG_N];

  initial begin
    decRs = '0; decRt = '0; decReadsRs = 1'b0; decReadsRt = 1'b0;
    laterDest = '0; laterRegWrite = '0; decRegWrite = 1'b0; decMemWrite = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset / idle state: empty pipeline, nothing held.
    checkOuts("R8 idle", 0, 0, 0);
    rstN = 1'b1;

    // Table walk.
    for (int i = 0; i < VEC_N; i++) begin
      @(negedge clk);
      driveVec(i);
      #1;
      checkOuts(tagOf(i), VECS[i][10], VECS[i][8], VECS[i][9]);
    end

    // R8: stall drops as soon as the producer leaves writeback.
    @(negedge clk);
    driveVec(3);
    #1;
    chk("R8", "stall while producer in writeback", int'(idExBubble), 1);
    laterRegWrite = '0;
    laterDest = '0;
    #1;
    chk("R8", "stall after producer retired", int'(idExBubble), 0);
    chk("R8", "pc resumes after producer retired", int'(pcWrEn), 1);

    // Pipeline model run.
    idIdx = -1; exIdx = -1; memIdx = -1; wbIdx = -1; pcIdx = 0;
    cyc = 0; stalls = 0; retired = 0; firstRet = -1; lastRet = -1;
    for (int k = 0; k < PROG_N; k++) perStall[k] = 0;
    while (retired < PROG_N && cyc < 200) begin
      inst_t d, e, m, w;
      @(negedge clk);
      d = progAt(idIdx);
      e = progAt(exIdx);
      m = progAt(memIdx);
      w = progAt(wbIdx);
      decRs         = (idIdx >= 0) ? AW'(d.rs) : '0;
      decRt         = (idIdx >= 0) ? AW'(d.rt) : '0;
      decReadsRs    = (idIdx >= 0) && d.rdRs;
      decReadsRt    = (idIdx >= 0) && d.rdRt;
      decRegWrite   = (idIdx >= 0) && d.we;
      decMemWrite   = (idIdx >= 0) && !d.we;
      laterDest     = {AW'(w.dest), AW'(m.dest), AW'(e.dest)};
      laterRegWrite = {(wbIdx >= 0) && w.we, (memIdx >= 0) && m.we, (exIdx >= 0) && e.we};
      #1;
      if (wbIdx >= 0) begin
        retired++;
        if (firstRet < 0) firstRet = cyc;
        lastRet = cyc;
      end
      if (!pcWrEn) begin
        stalls++;
        if (idIdx >= 0) perStall[idIdx]++;
      end
      wbIdx  = memIdx;
      memIdx = exIdx;
      exIdx  = idExBubble ? -1 : idIdx;
      if (ifIdWrEn) begin
        idIdx = (pcIdx < PROG_N) ? pcIdx : -1;
        if (pcIdx < PROG_N) pcIdx++;
      end
      cyc++;
    end

    chk("R9", "stalls for distance 1 consumer", perStall[1], 3);
    chk("R9", "stalls for distance 2 consumer", perStall[4], 2);
    chk("R9", "stalls for distance 3 consumer", perStall[8], 1);
    chk("R8", "stalls for distance 4 consumer", perStall[13], 0);
    chk("R9", "total stall cycles", stalls, 6);
    chk("R9", "instructions retired", retired, PROG_N);
    chk("R9", "retire span equals N+S", lastRet - firstRet + 1, PROG_N + 6);

    finishRun();
  end

endmodule